// File: doc/BRIEF.md
# Read-Triggered Self-Test for a Tag Array and a Target Array

This block holds two small on-chip RAMs: a tag array and a target array. Each array has its own march-test engine. Outside a test, the rest of the chip reads and writes both arrays through plain synchronous ports. The only way to start a test is to read a 64-bit read-only status word. The block has no start bit.

When the read request arrives and no feature-enable input is set, both engines start in the same cycle. While they run, the block owns both arrays. The read stays unacknowledged until both engines report done. The acknowledge then rises for exactly one cycle with two pass flags in the low bits of the returned word.

If any of the three feature enables is set, the read completes at once with an all-zero word and the arrays are not touched. The tag engine ends every run with a full pass that writes zero to every entry. Because of this, the tag array comes out cleared whether the test passed or failed. A fault input forces one stored bit of either array to a fixed value on its read path, so that the failure path can be exercised.

Top module: `dualRamBist`

## Requirements
- R1: A read request (`statRdReq` high in an idle cycle) with `cfgFeatureEn` equal to zero starts both engines at the next clock edge. `statRdAck` stays low until both engines have finished, which takes at least as many cycles as the tag engine's march plus its clearing pass (768 cycles at default sizes).
- R2: `statRdAck` is high for exactly one cycle per accepted read. In that cycle, bit 1 of `statRdData` is the target pass flag, bit 0 is the tag pass flag (1 means passed), and bits 63:2 are zero.
- R3: If any bit of `cfgFeatureEn` is set when the read is accepted, `statRdAck` rises in the cycle after the accepting edge and `statRdData` is all zeros. Bit 0 is the level-1 branch cache, bit 1 is the level-0 branch cache and bit 2 is the return stack. No test runs and the contents of both arrays are unchanged.
- R4: A run on fault-free arrays returns the value 3 (both flags set).
- R5: Every engine compares every read of its march. The first mismatch sets a fail flag that holds until the next run starts. A stuck bit in the tag array gives the value 2, and a stuck bit in the target array gives the value 1.
- R6: After every run, pass or fail, every tag array entry reads as zero.
- R7: From the accepting edge until the acknowledge cycle ends, `busy` is high and the external write enables of both arrays have no effect on array contents.
- R8: During reset, `statRdAck` is 0, `statRdData` is 0 and `busy` is 0.
- R9: Outside a test, a write on an external port stores the data. The read data for the address presented in one cycle appears on the read-data output after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgFeatureEn | input | 3 | Feature enables: bit0 level-1 branch cache, bit1 level-0 branch cache, bit2 return stack |
| statRdReq | input | 1 | Status read request, held until acknowledged |
| statRdAck | output | 1 | One-cycle read completion |
| statRdData | output | 64 | Status word, valid with the acknowledge |
| busy | output | 1 | Block owns the arrays |
| tagAddr | input | 6 | External tag address |
| tagWe | input | 1 | External tag write enable |
| tagWdata | input | 20 | External tag write data |
| tagRdata | output | 20 | Tag read data, one cycle after the address |
| tgtAddr | input | 6 | External target address |
| tgtWe | input | 1 | External target write enable |
| tgtWdata | input | 32 | External target write data |
| tgtRdata | output | 32 | Target read data, one cycle after the address |
| faultEn | input | 1 | Enable the injected stuck bit |
| faultOnTarget | input | 1 | 0 selects the tag array, 1 selects the target array |
| faultAddr | input | 6 | Entry holding the stuck bit |
| faultBit | input | 5 | Bit position of the stuck bit |
| faultVal | input | 1 | Value the stuck bit reads as |

## Verification
Failures are the hardest case to reach: on sound arrays the march never sees a mismatch. The bench therefore uses the fault port to make one bit of one array read as a constant. It sweeps the stuck value, the corner entries and the edge bit positions of both arrays, and expects exactly the flag for the faulty array to drop. A second hard case is an external write that leaks into the arrays during a run. To cover it, the bench holds both external write enables high through a whole run and requires the run to still pass. A single leaked write would corrupt the march pattern and be reported as a failure.

// File: rtl/bistPkg.sv
package bistPkg;

  typedef struct packed {
    logic start;     // one-cycle: launch both engines
    logic testMode;  // engines own the arrays
  } bistStrobe_t;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_RUN  = 2'd1,
    CS_RESP = 2'd2
  } ctrlState_e;

endpackage

// File: rtl/ramArray.sv
module ramArray #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 20,
  parameter int AW    = $clog2(DEPTH),
  parameter int BW    = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic             faultEn,
  input  logic [AW-1:0]    faultAddr,
  input  logic [BW-1:0]    faultBit,
  input  logic             faultVal
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] readWord;

  // injected stuck bit sits on the read path of one entry
  always_comb begin
    readWord = mem[addr];
    if (faultEn && (addr == faultAddr)) readWord[faultBit] = faultVal;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= readWord;
  end

endmodule

// File: rtl/marchEngine.sv
module marchEngine #(
  parameter int DEPTH       = 64,
  parameter int WIDTH       = 20,
  parameter int CLEAR_AFTER = 0,
  parameter int AW          = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] rdata,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic [AW-1:0]    addr,
  output logic             we,
  output logic [WIDTH-1:0] wdata
);

  // elements: 0 w0 up | 1 r0w1 up | 2 r1w0 up | 3 r0w1 down | 4 r1w0 down
  //           5 r0 up | 6 w0 up (clearing pass, only when CLEAR_AFTER)
  localparam logic [2:0]       LAST_ELEM = (CLEAR_AFTER != 0) ? 3'd6 : 3'd5;
  localparam logic [AW-1:0]    TOP_ADDR  = AW'(DEPTH - 1);
  localparam logic [WIDTH-1:0] ONES      = {WIDTH{1'b1}};

  logic          running, phase, failQ, doneQ;
  logic [2:0]    elem, nextElem;
  logic [AW-1:0] addrQ;
  logic          writeOnly, descending, expectOnes, writeOnes, hasWrite;
  logic          nextDesc, atLast, stepDone, mismatch;

  always_comb begin
    writeOnly  = (elem == 3'd0) || (elem == 3'd6);
    descending = (elem == 3'd3) || (elem == 3'd4);
    expectOnes = (elem == 3'd2) || (elem == 3'd4);
    writeOnes  = (elem == 3'd1) || (elem == 3'd3);
    hasWrite   = (elem != 3'd5);
    nextElem   = elem + 3'd1;
    nextDesc   = (nextElem == 3'd3) || (nextElem == 3'd4);
    atLast     = descending ? (addrQ == '0) : (addrQ == TOP_ADDR);
    stepDone   = running && (writeOnly || phase);
    mismatch   = running && !writeOnly && phase &&
                 (rdata != (expectOnes ? ONES : '0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      phase   <= 1'b0;
      failQ   <= 1'b0;
      doneQ   <= 1'b0;
      elem    <= 3'd0;
      addrQ   <= '0;
    end else if (start) begin
      running <= 1'b1;
      phase   <= 1'b0;
      failQ   <= 1'b0;
      doneQ   <= 1'b0;
      elem    <= 3'd0;
      addrQ   <= '0;
    end else if (running) begin
      if (mismatch)   failQ <= 1'b1;
      if (!writeOnly) phase <= !phase;
      if (stepDone) begin
        phase <= 1'b0;
        if (atLast) begin
          if (elem == LAST_ELEM) begin
            running <= 1'b0;
            doneQ   <= 1'b1;
          end else begin
            elem  <= nextElem;
            addrQ <= nextDesc ? TOP_ADDR : '0;
          end
        end else begin
          addrQ <= descending ? addrQ - 1'b1 : addrQ + 1'b1;
        end
      end
    end
  end

  assign busy  = running;
  assign done  = doneQ;
  assign pass  = !failQ;
  assign addr  = addrQ;
  assign we    = running && hasWrite && (writeOnly || phase);
  assign wdata = writeOnes ? ONES : '0;

  assert_start_runs_R1: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (busy && !done));
  assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R5: fail flag is sticky for the rest of a run
  assert_fail_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!pass && !start) |=> !pass);

endmodule

// File: rtl/bistCtrl.sv
module bistCtrl
  import bistPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdReq,
  input  logic [2:0]  featureEn,
  input  logic        engDone,
  input  logic [1:0]  engPass,
  output bistStrobe_t strobe,
  output logic        rdAck,
  output logic [63:0] rdData,
  output logic        busy
);

  ctrlState_e state;
  logic [1:0] respQ;
  logic       blocked;

  assign blocked = |featureEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= CS_IDLE;
      respQ <= 2'b00;
    end else begin
      unique case (state)
        CS_IDLE: if (rdReq) begin
          if (blocked) begin
            state <= CS_RESP;
            respQ <= 2'b00;
          end else begin
            state <= CS_RUN;
          end
        end
        CS_RUN: if (engDone) begin
          state <= CS_RESP;
          respQ <= engPass;
        end
        CS_RESP: state <= CS_IDLE;
        default: state <= CS_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.start    = (state == CS_IDLE) && rdReq && !blocked;
    strobe.testMode = (state != CS_IDLE);
  end

  assign rdAck  = (state == CS_RESP);
  assign rdData = {62'd0, rdAck ? respQ : 2'b00};
  assign busy   = strobe.testMode;

  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdAck |=> !rdAck);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[63:2] == 62'd0);
  assert_blocked_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((state == CS_IDLE) && rdReq && blocked) |=> (rdAck && rdData == 64'd0));
  assert_no_early_ack_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((state == CS_RUN) && !engDone) |=> !rdAck);

endmodule

// File: rtl/bistDatapath.sv
module bistDatapath
  import bistPkg::*;
#(
  parameter int TAG_DEPTH = 64,
  parameter int TAG_WIDTH = 20,
  parameter int TGT_DEPTH = 64,
  parameter int TGT_WIDTH = 32,
  parameter int TAG_AW    = $clog2(TAG_DEPTH),
  parameter int TGT_AW    = $clog2(TGT_DEPTH),
  parameter int TAG_BW    = $clog2(TAG_WIDTH),
  parameter int TGT_BW    = $clog2(TGT_WIDTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bistStrobe_t          strobe,
  input  logic [TAG_AW-1:0]    tagAddr,
  input  logic                 tagWe,
  input  logic [TAG_WIDTH-1:0] tagWdata,
  output logic [TAG_WIDTH-1:0] tagRdata,
  input  logic [TGT_AW-1:0]    tgtAddr,
  input  logic                 tgtWe,
  input  logic [TGT_WIDTH-1:0] tgtWdata,
  output logic [TGT_WIDTH-1:0] tgtRdata,
  input  logic                 tagFaultEn,
  input  logic [TAG_AW-1:0]    tagFaultAddr,
  input  logic [TAG_BW-1:0]    tagFaultBit,
  input  logic                 tgtFaultEn,
  input  logic [TGT_AW-1:0]    tgtFaultAddr,
  input  logic [TGT_BW-1:0]    tgtFaultBit,
  input  logic                 faultVal,
  output logic                 engDone,
  output logic [1:0]           engPass
);

  logic                 tagEngBusy, tagEngDone, tagEngPass, tagEngWe;
  logic [TAG_AW-1:0]    tagEngAddr, tagMuxAddr;
  logic [TAG_WIDTH-1:0] tagEngWdata, tagMuxWdata;
  logic                 tagMuxWe;

  logic                 tgtEngBusy, tgtEngDone, tgtEngPass, tgtEngWe;
  logic [TGT_AW-1:0]    tgtEngAddr, tgtMuxAddr;
  logic [TGT_WIDTH-1:0] tgtEngWdata, tgtMuxWdata;
  logic                 tgtMuxWe;

  marchEngine #(.DEPTH(TAG_DEPTH), .WIDTH(TAG_WIDTH), .CLEAR_AFTER(1)) uTagEng (
    .clk, .rstN, .start(strobe.start), .rdata(tagRdata),
    .busy(tagEngBusy), .done(tagEngDone), .pass(tagEngPass),
    .addr(tagEngAddr), .we(tagEngWe), .wdata(tagEngWdata)
  );

  marchEngine #(.DEPTH(TGT_DEPTH), .WIDTH(TGT_WIDTH), .CLEAR_AFTER(0)) uTgtEng (
    .clk, .rstN, .start(strobe.start), .rdata(tgtRdata),
    .busy(tgtEngBusy), .done(tgtEngDone), .pass(tgtEngPass),
    .addr(tgtEngAddr), .we(tgtEngWe), .wdata(tgtEngWdata)
  );

  // engines own both arrays for the whole test window
  always_comb begin
    tagMuxAddr  = strobe.testMode ? tagEngAddr  : tagAddr;
    tagMuxWe    = strobe.testMode ? tagEngWe    : tagWe;
    tagMuxWdata = strobe.testMode ? tagEngWdata : tagWdata;
    tgtMuxAddr  = strobe.testMode ? tgtEngAddr  : tgtAddr;
    tgtMuxWe    = strobe.testMode ? tgtEngWe    : tgtWe;
    tgtMuxWdata = strobe.testMode ? tgtEngWdata : tgtWdata;
  end

  ramArray #(.DEPTH(TAG_DEPTH), .WIDTH(TAG_WIDTH)) uTagRam (
    .clk, .we(tagMuxWe), .addr(tagMuxAddr), .wdata(tagMuxWdata), .rdata(tagRdata),
    .faultEn(tagFaultEn), .faultAddr(tagFaultAddr), .faultBit(tagFaultBit),
    .faultVal(faultVal)
  );

  ramArray #(.DEPTH(TGT_DEPTH), .WIDTH(TGT_WIDTH)) uTgtRam (
    .clk, .we(tgtMuxWe), .addr(tgtMuxAddr), .wdata(tgtMuxWdata), .rdata(tgtRdata),
    .faultEn(tgtFaultEn), .faultAddr(tgtFaultAddr), .faultBit(tgtFaultBit),
    .faultVal(faultVal)
  );

  assign engDone = tagEngDone && tgtEngDone;
  assign engPass = {tgtEngPass, tagEngPass};

  assert_engine_owns_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tagEngBusy || tgtEngBusy) |-> strobe.testMode);
  assert_lockstep_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> (tagEngBusy && tgtEngBusy));

endmodule

// File: rtl/dualRamBist.sv
module dualRamBist
  import bistPkg::*;
#(
  parameter int TAG_DEPTH = 64,
  parameter int TAG_WIDTH = 20,
  parameter int TGT_DEPTH = 64,
  parameter int TGT_WIDTH = 32,
  parameter int TAG_AW    = $clog2(TAG_DEPTH),
  parameter int TGT_AW    = $clog2(TGT_DEPTH),
  parameter int TAG_BW    = $clog2(TAG_WIDTH),
  parameter int TGT_BW    = $clog2(TGT_WIDTH),
  parameter int FA_W      = (TAG_AW > TGT_AW) ? TAG_AW : TGT_AW,
  parameter int FB_W      = (TAG_BW > TGT_BW) ? TAG_BW : TGT_BW
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           cfgFeatureEn,
  input  logic                 statRdReq,
  output logic                 statRdAck,
  output logic [63:0]          statRdData,
  output logic                 busy,
  input  logic [TAG_AW-1:0]    tagAddr,
  input  logic                 tagWe,
  input  logic [TAG_WIDTH-1:0] tagWdata,
  output logic [TAG_WIDTH-1:0] tagRdata,
  input  logic [TGT_AW-1:0]    tgtAddr,
  input  logic                 tgtWe,
  input  logic [TGT_WIDTH-1:0] tgtWdata,
  output logic [TGT_WIDTH-1:0] tgtRdata,
  input  logic                 faultEn,
  input  logic                 faultOnTarget,
  input  logic [FA_W-1:0]      faultAddr,
  input  logic [FB_W-1:0]      faultBit,
  input  logic                 faultVal
);

  bistStrobe_t strobe;
  logic        engDone;
  logic [1:0]  engPass;

  bistCtrl uCtrl (
    .clk, .rstN, .rdReq(statRdReq), .featureEn(cfgFeatureEn),
    .engDone, .engPass, .strobe, .rdAck(statRdAck), .rdData(statRdData), .busy
  );

  bistDatapath #(
    .TAG_DEPTH(TAG_DEPTH), .TAG_WIDTH(TAG_WIDTH),
    .TGT_DEPTH(TGT_DEPTH), .TGT_WIDTH(TGT_WIDTH)
  ) uData (
    .clk, .rstN, .strobe,
    .tagAddr, .tagWe, .tagWdata, .tagRdata,
    .tgtAddr, .tgtWe, .tgtWdata, .tgtRdata,
    .tagFaultEn(faultEn && !faultOnTarget),
    .tagFaultAddr(faultAddr[TAG_AW-1:0]),
    .tagFaultBit(faultBit[TAG_BW-1:0]),
    .tgtFaultEn(faultEn && faultOnTarget),
    .tgtFaultAddr(faultAddr[TGT_AW-1:0]),
    .tgtFaultBit(faultBit[TGT_BW-1:0]),
    .faultVal,
    .engDone, .engPass
  );

endmodule

// File: tb/sim_dualRamBist.sv
module sim_dualRamBist;
  localparam int TAG_D = 64, TAG_W = 20, TGT_D = 64, TGT_W = 32;
  localparam int MIN_RUN = TAG_D + 5 * 2 * TAG_D + TAG_D; // 768

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic        rstN = 1'b0;
  logic [2:0]  cfgFeatureEn = '0;
  logic        statRdReq = 1'b0, statRdAck, busy;
  logic [63:0] statRdData;
  logic [5:0]  tagAddr = '0, tgtAddr = '0;
  logic        tagWe = 1'b0, tgtWe = 1'b0;
  logic [TAG_W-1:0] tagWdata = '0, tagRdata;
  logic [TGT_W-1:0] tgtWdata = '0, tgtRdata;
  logic        faultEn = 1'b0, faultOnTarget = 1'b0, faultVal = 1'b0;
  logic [5:0]  faultAddr = '0;
  logic [4:0]  faultBit = '0;

  dualRamBist u0 (
    .clk, .rstN, .cfgFeatureEn, .statRdReq, .statRdAck, .statRdData, .busy,
    .tagAddr, .tagWe, .tagWdata, .tagRdata,
    .tgtAddr, .tgtWe, .tgtWdata, .tgtRdata,
    .faultEn, .faultOnTarget, .faultAddr, .faultBit, .faultVal
  );

  int nChecks = 0, nFails = 0;

  task automatic check(input bit ok, input string req,
                       input longint unsigned act, input longint unsigned exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [TAG_W-1:0] tagPat(input int a);
    return TAG_W'(a * 3379 + 17);
  endfunction
  function automatic logic [TGT_W-1:0] tgtPat(input int a);
    return TGT_W'(a * 32'h9E37_79B1 + 5);
  endfunction

  task automatic tagWrite(input int a, input logic [TAG_W-1:0] d);
    @(negedge clk); tagAddr = 6'(a); tagWdata = d; tagWe = 1'b1;
    @(negedge clk); tagWe = 1'b0;
  endtask
  task automatic tgtWrite(input int a, input logic [TGT_W-1:0] d);
    @(negedge clk); tgtAddr = 6'(a); tgtWdata = d; tgtWe = 1'b1;
    @(negedge clk); tgtWe = 1'b0;
  endtask
  task automatic tagRead(input int a, output logic [TAG_W-1:0] d);
    @(negedge clk); tagAddr = 6'(a);
    @(negedge clk); d = tagRdata;
  endtask
  task automatic tgtRead(input int a, output logic [TGT_W-1:0] d);
    @(negedge clk); tgtAddr = 6'(a);
    @(negedge clk); d = tgtRdata;
  endtask

  // R1 R2: issue a status read, wait for the acknowledge
  task automatic statusRead(output logic [63:0] d, output int cyc, output logic busyMid);
    @(negedge clk); statRdReq = 1'b1;
    cyc = 0; busyMid = 1'b0;
    forever begin
      @(negedge clk); cyc++;
      if (cyc == 50) busyMid = busy;
      if (statRdAck || cyc > 5000) break;
    end
    d = statRdData;
    statRdReq = 1'b0; tagWe = 1'b0; tgtWe = 1'b0;
    @(negedge clk);
    check(!statRdAck, "R2 ack lasts one cycle", statRdAck, 0);
  endtask

  task automatic tagAllZero(input string req);
    logic [TAG_W-1:0] v;
    int bad = 0;
    for (int a = 0; a < TAG_D; a++) begin
      tagRead(a, v);
      if (v != '0) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic faultRun(input bit onTgt, input int a, input int b, input bit val);
    logic [63:0] d; int cyc; logic bm;
    faultEn = 1'b1; faultOnTarget = onTgt; faultAddr = 6'(a);
    faultBit = 5'(b); faultVal = val;
    statusRead(d, cyc, bm);
    faultEn = 1'b0;
    check(d == (onTgt ? 64'd1 : 64'd2), "R5 stuck bit flags only its array", d,
          onTgt ? 64'd1 : 64'd2);
  endtask

  initial begin
    #(8 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [63:0] d; int cyc; logic bm;
    logic [TAG_W-1:0] tv; logic [TGT_W-1:0] gv;
    int bad;

    repeat (3) @(negedge clk);
    check(statRdAck == 0, "R8 reset ack", statRdAck, 0);
    check(statRdData == 0, "R8 reset data", statRdData, 0);
    check(busy == 0, "R8 reset busy", busy, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R9: sweep both arrays through the external ports
    for (int a = 0; a < TAG_D; a++) tagWrite(a, tagPat(a));
    for (int a = 0; a < TGT_D; a++) tgtWrite(a, tgtPat(a));
    bad = 0;
    for (int a = 0; a < TAG_D; a++) begin tagRead(a, tv); if (tv != tagPat(a)) bad++; end
    check(bad == 0, "R9 tag array readback", bad, 0);
    bad = 0;
    for (int a = 0; a < TGT_D; a++) begin tgtRead(a, gv); if (gv != tgtPat(a)) bad++; end
    check(bad == 0, "R9 target array readback", bad, 0);

    // R3: every nonzero enable combination blocks the test
    for (int e = 1; e < 8; e++) begin
      cfgFeatureEn = 3'(e);
      statusRead(d, cyc, bm);
      check(d == 0, "R3 blocked read returns zero", d, 0);
      check(cyc == 1, "R3 blocked read latency", cyc, 1);
    end
    cfgFeatureEn = '0;
    bad = 0;
    for (int a = 0; a < TAG_D; a += 9) begin tagRead(a, tv); if (tv != tagPat(a)) bad++; end
    for (int a = 0; a < TGT_D; a += 9) begin tgtRead(a, gv); if (gv != tgtPat(a)) bad++; end
    check(bad == 0, "R3 arrays untouched by blocked reads", bad, 0);

    // R1 R4 R7: clean run with external writes held on throughout
    @(negedge clk);
    tagAddr = 6'd7; tagWdata = '1; tagWe = 1'b1;
    tgtAddr = 6'd9; tgtWdata = 32'h1234_5678; tgtWe = 1'b1;
    statusRead(d, cyc, bm);
    check(d == 64'd3, "R4 clean run passes (R7 writes ignored)", d, 3);
    check(cyc >= MIN_RUN, "R1 ack withheld for whole test", cyc, MIN_RUN);
    check(bm == 1'b1, "R7 busy during test", bm, 1);
    check(busy == 0, "R7 busy released after ack", busy, 0);
    tagAllZero("R6 tag array cleared after pass");

    // R5: fault sweep over corners, edge bits and both stuck values
    foreach (d[i]) begin end
    for (int ai = 0; ai < 3; ai++)
      for (int bi = 0; bi < 2; bi++)
        for (int v = 0; v < 2; v++)
          faultRun(1'b0, (ai == 0) ? 0 : (ai == 1) ? 31 : TAG_D - 1,
                   (bi == 0) ? 0 : TAG_W - 1, v[0]);
    tagAllZero("R6 tag array cleared after failing run");
    for (int ai = 0; ai < 2; ai++)
      for (int bi = 0; bi < 2; bi++)
        for (int v = 0; v < 2; v++)
          faultRun(1'b1, (ai == 0) ? 0 : TGT_D - 1, (bi == 0) ? 0 : TGT_W - 1, v[0]);

    // R5: fail flag does not survive into the next run
    statusRead(d, cyc, bm);
    check(d == 64'd3, "R5 new run clears old failure", d, 3);

    // R2 R3: blocked read after a passing run still returns zero
    cfgFeatureEn = 3'b100;
    statusRead(d, cyc, bm);
    check(d == 0, "R3 blocked after pass", d, 0);
    cfgFeatureEn = '0;

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule